// File: doc/BRIEF.md
# Per-Flow Queue Output Scheduler

This block sits at an output port of a cell switch. Arriving cells carry a flow number and are written into a small first-in first-out queue kept for that flow. A scheduler then picks, in every cycle, which queue may offer its oldest cell to the outgoing link. The link accepts the offered cell with a ready handshake, so the scheduler decides both which queue sends and when a cell leaves.

Each queue uses drop-tail buffer management. A cell that arrives when its queue is already full is thrown away, the cells already stored stay, and a one-cycle drop pulse reports the affected flow. A mode input chooses between two service disciplines at run time: strict priority, where a lower flow number always wins, and round robin, where non-empty queues take turns one cell at a time.

Top module: `flow_sched_top`

## Requirements
- R1: Cells of one flow leave in the order in which they were accepted into that flow's queue.
- R2: A cell arriving (enq_valid high) for a queue that holds DEPTH cells at the start of the cycle is discarded and the stored cells are kept; in that cycle drop_pulse is high and drop_flow equals the arriving flow number; in every other cycle drop_pulse is low.
- R3: A queue accepts exactly DEPTH cells; a cycle that both accepts and removes a cell on the same queue leaves its occupancy unchanged.
- R4: With mode_rr low (strict priority), the offered cell comes from the non-empty queue with the lowest flow number; flow 0 is the highest priority.
- R5: With mode_rr high (round robin), the offered cell comes from the first non-empty queue at or after a pointer, counting upward and wrapping; after every accepted cell the pointer moves to the flow after the one served, so empty queues are skipped.
- R6: A cell leaves only in a cycle where deq_valid and deq_ready are both high; while deq_ready is low, deq_valid stays high and nothing is removed.
- R7: deq_valid is low whenever every queue is empty, including after reset; reset empties all queues.
- R8: deq_flow gives the flow number of the queue whose head cell is on deq_data.
- R9: Fullness is judged at the start of the cycle: an arrival to a full queue is dropped even if that queue sends a cell in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_rr | input | 1 | 0 = strict priority, 1 = round robin |
| enq_valid | input | 1 | An arriving cell is present |
| enq_flow | input | $clog2(NUM_FLOWS) | Flow number of the arriving cell |
| enq_data | input | DATA_W | Arriving cell payload |
| drop_pulse | output | 1 | Arriving cell discarded this cycle |
| drop_flow | output | $clog2(NUM_FLOWS) | Flow number of the discarded cell |
| deq_valid | output | 1 | A cell is offered to the link |
| deq_ready | input | 1 | Link accepts the offered cell |
| deq_flow | output | $clog2(NUM_FLOWS) | Flow number of the offered cell |
| deq_data | output | DATA_W | Offered cell payload |

## Verification
The bench builds the block with four flows, 8-bit cells and a queue depth of two. The shallow depth lets a queue fill in two arrivals, so drop-tail, the full-queue arrival that coincides with a departure, and the refill after a simultaneous push and pop are all reached within a few cycles. Four flows are enough for the round-robin pointer to wrap past the top flow and to skip empty queues, and for a lower-numbered flow to overtake a higher one in priority mode.

// File: rtl/flowq_pkg.sv
`timescale 1ns/1ps
package flowq_pkg;
  typedef enum logic {
    SVC_STRICT = 1'b0,
    SVC_TURNS  = 1'b1
  } svc_mode_e;
endpackage

// File: rtl/rst_release.sv
`timescale 1ns/1ps
module rst_release (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/cell_fifo.sv
`timescale 1ns/1ps
module cell_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [DATA_W-1:0]          din,
  input  logic                       pop,
  output logic [DATA_W-1:0]          dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

  logic [DATA_W-1:0] store_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              take, give;

  assign full  = (cnt_q == CAP);
  assign empty = (cnt_q == '0);
  assign take  = push && !full;
  assign give  = pop && !empty;
  assign dout  = store_q[rd_q];
  assign count = cnt_q;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (take) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (give) rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    case ({take, give})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take) store_q[wr_q] <= din;
  end

  // R3: occupancy never exceeds the queue depth
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CAP);

  // R3: simultaneous accept and removal keeps the occupancy
  a_r3_push_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (take && give) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/flow_picker.sv
`timescale 1ns/1ps
module flow_picker
  import flowq_pkg::*;
#(
  parameter int NUM_FLOWS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_FLOWS-1:0]         busy,
  input  svc_mode_e                    mode,
  input  logic                         advance,
  output logic [$clog2(NUM_FLOWS)-1:0] sel,
  output logic                         any
);
  localparam int FID_W = $clog2(NUM_FLOWS);
  localparam logic [FID_W-1:0] TOP = FID_W'(NUM_FLOWS - 1);

  logic [FID_W-1:0] ptr_q, ptr_d;
  logic [FID_W-1:0] strict_sel, turn_sel;

  assign any = |busy;

  always_comb begin
    strict_sel = '0;
    for (int i = NUM_FLOWS - 1; i >= 0; i--) begin
      if (busy[i]) strict_sel = FID_W'(i);
    end
  end

  always_comb begin
    turn_sel = ptr_q;
    for (int k = NUM_FLOWS - 1; k >= 0; k--) begin
      int idx;
      idx = int'(ptr_q) + k;
      if (idx >= NUM_FLOWS) idx = idx - NUM_FLOWS;
      if (busy[idx]) turn_sel = FID_W'(idx);
    end
  end

  assign sel = (mode == SVC_TURNS) ? turn_sel : strict_sel;

  always_comb begin
    ptr_d = ptr_q;
    if (advance && any) ptr_d = (sel == TOP) ? '0 : sel + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // R5: in turn mode the chosen queue holds a cell whenever any does
  a_r5_pick_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (any && mode == SVC_TURNS) |-> busy[sel]);
endmodule

// File: rtl/flow_sched_top.sv
`timescale 1ns/1ps
module flow_sched_top
  import flowq_pkg::*;
#(
  parameter int NUM_FLOWS = 4,
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         mode_rr,
  input  logic                         enq_valid,
  input  logic [$clog2(NUM_FLOWS)-1:0] enq_flow,
  input  logic [DATA_W-1:0]            enq_data,
  output logic                         drop_pulse,
  output logic [$clog2(NUM_FLOWS)-1:0] drop_flow,
  output logic                         deq_valid,
  input  logic                         deq_ready,
  output logic [$clog2(NUM_FLOWS)-1:0] deq_flow,
  output logic [DATA_W-1:0]            deq_data
);
  localparam int FID_W = $clog2(NUM_FLOWS);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

  logic                 rst_s;
  logic [NUM_FLOWS-1:0] q_full, q_empty, q_push, q_pop;
  logic [DATA_W-1:0]    q_head [NUM_FLOWS];
  logic [CNT_W-1:0]     q_cnt  [NUM_FLOWS];
  logic [FID_W-1:0]     pick;
  logic                 any_cell;
  logic                 send;
  svc_mode_e            mode;

  rst_release u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s)
  );

  assign mode = mode_rr ? SVC_TURNS : SVC_STRICT;
  assign send = any_cell && deq_ready;

  for (genvar f = 0; f < NUM_FLOWS; f++) begin : g_flow
    assign q_push[f] = enq_valid && (enq_flow == FID_W'(f));
    assign q_pop[f]  = send && (pick == FID_W'(f));

    cell_fifo #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
    ) u_q (
      .clk   (clk),
      .rst_n (rst_s),
      .push  (q_push[f]),
      .din   (enq_data),
      .pop   (q_pop[f]),
      .dout  (q_head[f]),
      .count (q_cnt[f]),
      .full  (q_full[f]),
      .empty (q_empty[f])
    );
  end

  flow_picker #(
    .NUM_FLOWS (NUM_FLOWS)
  ) u_pick (
    .clk     (clk),
    .rst_n   (rst_s),
    .busy    (~q_empty),
    .mode    (mode),
    .advance (send),
    .sel     (pick),
    .any     (any_cell)
  );

  assign deq_valid  = any_cell;
  assign deq_flow   = pick;
  assign deq_data   = q_head[pick];
  assign drop_pulse = enq_valid && q_full[enq_flow];
  assign drop_flow  = enq_flow;

  // R7: nothing is offered while every queue is empty
  a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_s)
    (&q_empty) |-> !deq_valid);

  // R6: a stalled offer stays up until the link takes it
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_s)
    (deq_valid && !deq_ready) |=> deq_valid);

  // R4: strict mode never passes over a lower-numbered busy queue
  a_r4_strict_order: assert property (@(posedge clk) disable iff (!rst_s)
    (deq_valid && !mode_rr) |->
      ((~q_empty & ((NUM_FLOWS'(1) << deq_flow) - 1'b1)) == '0));

  // R2: a dropped arrival leaves the queue full when it sent nothing
  a_r2_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_s)
    (drop_pulse && !q_pop[drop_flow]) |=> (q_cnt[$past(drop_flow)] == CAP));
endmodule

// File: tb/tb_flow_sched_top.sv
`timescale 1ns/1ps
module tb_flow_sched_top;
  localparam int NF = 4;
  localparam int DW = 8;
  localparam int DP = 2;
  localparam int FW = $clog2(NF);
  localparam int NV = 24;

  typedef struct packed {
    logic          mode;
    logic          ev;
    logic [FW-1:0] ef;
    logic [DW-1:0] ed;
    logic          rdy;
    logic          xv;
    logic [FW-1:0] xf;
    logic [DW-1:0] xd;
    logic          xdrop;
  } vec_t;

  // one row per cycle; expectations hold before the closing clock edge
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,2'd2,8'h20,1'b0, 1'b0,2'd0,8'h00,1'b0}, // R7 empty at start
    '{1'b0,1'b1,2'd2,8'h21,1'b0, 1'b1,2'd2,8'h20,1'b0},
    '{1'b0,1'b1,2'd2,8'h22,1'b0, 1'b1,2'd2,8'h20,1'b1}, // R2 third arrival
    '{1'b0,1'b1,2'd1,8'h10,1'b0, 1'b1,2'd2,8'h20,1'b0}, // R6 stall
    '{1'b0,1'b1,2'd3,8'h30,1'b0, 1'b1,2'd1,8'h10,1'b0}, // R4 flow1 over 2
    '{1'b0,1'b0,2'd0,8'h00,1'b1, 1'b1,2'd1,8'h10,1'b0},
    '{1'b0,1'b0,2'd0,8'h00,1'b1, 1'b1,2'd2,8'h20,1'b0}, // R1
    '{1'b0,1'b1,2'd0,8'h05,1'b1, 1'b1,2'd2,8'h21,1'b0},
    '{1'b1,1'b0,2'd0,8'h00,1'b1, 1'b1,2'd3,8'h30,1'b0}, // R5 pointer at 3
    '{1'b1,1'b1,2'd2,8'h23,1'b0, 1'b1,2'd0,8'h05,1'b0}, // R5 wrap to 0
    '{1'b1,1'b1,2'd1,8'h11,1'b1, 1'b1,2'd0,8'h05,1'b0},
    '{1'b1,1'b1,2'd0,8'h06,1'b1, 1'b1,2'd1,8'h11,1'b0},
    '{1'b1,1'b0,2'd0,8'h00,1'b1, 1'b1,2'd2,8'h23,1'b0},
    '{1'b1,1'b0,2'd0,8'h00,1'b1, 1'b1,2'd0,8'h06,1'b0}, // R5 skip empty 3
    '{1'b1,1'b0,2'd0,8'h00,1'b1, 1'b0,2'd0,8'h00,1'b0}, // R7
    '{1'b1,1'b1,2'd3,8'h31,1'b0, 1'b0,2'd0,8'h00,1'b0},
    '{1'b1,1'b1,2'd3,8'h32,1'b0, 1'b1,2'd3,8'h31,1'b0},
    '{1'b1,1'b1,2'd3,8'h33,1'b1, 1'b1,2'd3,8'h31,1'b1}, // R9 drop while sending
    '{1'b1,1'b1,2'd3,8'h34,1'b1, 1'b1,2'd3,8'h32,1'b0}, // R3 push and pop
    '{1'b1,1'b1,2'd3,8'h35,1'b0, 1'b1,2'd3,8'h34,1'b0}, // R3 room for one
    '{1'b1,1'b1,2'd3,8'h36,1'b0, 1'b1,2'd3,8'h34,1'b1}, // R3 full again
    '{1'b1,1'b0,2'd0,8'h00,1'b1, 1'b1,2'd3,8'h34,1'b0},
    '{1'b1,1'b0,2'd0,8'h00,1'b1, 1'b1,2'd3,8'h35,1'b0}, // R9 33 never seen
    '{1'b1,1'b0,2'd0,8'h00,1'b1, 1'b0,2'd0,8'h00,1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mode_rr;
  logic          enq_valid;
  logic [FW-1:0] enq_flow;
  logic [DW-1:0] enq_data;
  logic          drop_pulse;
  logic [FW-1:0] drop_flow;
  logic          deq_valid;
  logic          deq_ready;
  logic [FW-1:0] deq_flow;
  logic [DW-1:0] deq_data;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  flow_sched_top #(.NUM_FLOWS(NF), .DATA_W(DW), .DEPTH(DP)) dut (
    .clk(clk), .rst_n(rst_n), .mode_rr(mode_rr),
    .enq_valid(enq_valid), .enq_flow(enq_flow), .enq_data(enq_data),
    .drop_pulse(drop_pulse), .drop_flow(drop_flow),
    .deq_valid(deq_valid), .deq_ready(deq_ready),
    .deq_flow(deq_flow), .deq_data(deq_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic m, input logic ev, input logic [FW-1:0] ef,
                       input logic [DW-1:0] ed, input logic rdy);
    mode_rr = m; enq_valid = ev; enq_flow = ef; enq_data = ed; deq_ready = rdy;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b0, 1'b0, '0, '0, 1'b0);
    repeat (3) @(negedge clk);
    #1;
    chk(deq_valid == 1'b0, "R7 reset valid", deq_valid, 0);
    chk(drop_pulse == 1'b0, "R2 reset drop", drop_pulse, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i].mode, VECS[i].ev, VECS[i].ef, VECS[i].ed, VECS[i].rdy);
      #1;
      chk(deq_valid == VECS[i].xv, $sformatf("R7 R6 valid row %0d", i),
          deq_valid, VECS[i].xv);
      if (VECS[i].xv) begin
        chk(deq_flow == VECS[i].xf, $sformatf("R4 R5 R8 flow row %0d", i),
            deq_flow, VECS[i].xf);
        chk(deq_data == VECS[i].xd, $sformatf("R1 data row %0d", i),
            deq_data, VECS[i].xd);
      end
      chk(drop_pulse == VECS[i].xdrop, $sformatf("R2 R9 drop row %0d", i),
          drop_pulse, VECS[i].xdrop);
      if (VECS[i].xdrop)
        chk(drop_flow == VECS[i].ef, $sformatf("R2 drop flow row %0d", i),
            drop_flow, VECS[i].ef);
    end

    // R7: reset in mid-run empties the queues
    @(negedge clk); drive(1'b0, 1'b1, 2'd1, 8'h41, 1'b0);
    @(negedge clk); drive(1'b0, 1'b1, 2'd1, 8'h42, 1'b0);
    #1;
    chk(deq_valid == 1'b1 && deq_data == 8'h41, "R1 before reset", deq_data, 8'h41);
    @(negedge clk); drive(1'b0, 1'b0, '0, '0, 1'b0);
    rst_n = 1'b0;
    #1;
    chk(deq_valid == 1'b0, "R7 mid reset", deq_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(deq_valid == 1'b0, "R7 after reset", deq_valid, 0);

    // R6: no departure without ready over several stalled cycles
    @(negedge clk); drive(1'b1, 1'b1, 2'd2, 8'h55, 1'b0);
    @(negedge clk); drive(1'b1, 1'b0, '0, '0, 1'b0);
    repeat (3) @(negedge clk);
    #1;
    chk(deq_valid == 1'b1 && deq_data == 8'h55, "R6 held cell", deq_data, 8'h55);
    @(negedge clk); drive(1'b1, 1'b0, '0, '0, 1'b1);
    #1;
    chk(deq_flow == 2'd2, "R8 flow of held cell", deq_flow, 2);
    @(negedge clk); drive(1'b1, 1'b0, '0, '0, 1'b0);
    #1;
    chk(deq_valid == 1'b0, "R6 single departure", deq_valid, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule